// File: doc/BRIEF.md
# Tightly Coupled Memory Arbiter

This block places four requesters in front of two single-cycle memories: an instruction memory with one 64-bit port and a data memory split into two independent 32-bit banks. The requesters are a debug port, a load/store port, a slave bus port through which DMA agents reach both memories, and a prefetch port that may only read. Each cycle, every requester is routed to the memory port its address selects, and contention for a port is settled by a fixed priority.

A request is granted or held in the cycle it is presented. `ready_o` reports the grant combinationally. A held requester keeps its request up until it is granted. A granted read returns its data exactly one cycle later, with `rvalid_o`. Two data accesses that fall in opposite banks complete together. A write from the prefetch port never reaches memory and is answered with an error pulse.

Top module: `tcm_arbiter`

## Requirements
- R1: Requester index sets a fixed priority: 0 debug, 1 load/store, 2 slave bus, 3 prefetch, with a lower index winning any shared memory port.
- R2: A requester that loses keeps `ready_o` low for as long as a higher-priority requester holds its target port. It is granted in the first cycle that port is free.
- R3: Address bit AW-1 selects the target: 0 for instruction memory, 1 for data memory. Data bank is address bit 2. The word index in either memory is taken from address bits 3 upward.
- R4: Two requests to opposite data banks are both granted in the same cycle.
- R5: Instruction reads return all 64 bits. Data reads return 32 bits in `rdata_o[31:0]` with the upper half zero.
- R6: A granted read raises `rvalid_o` with its data exactly one cycle after the grant cycle, for one cycle only. A write produces no `rvalid_o`.
- R7: Byte strobe bit k enables byte k of a write. Instruction writes use all eight strobes. Data writes use strobes 3:0.
- R8: A prefetch write is accepted (`ready_o[3]` high), leaves both memories unchanged, occupies no port, and pulses `err_o[3]` one cycle later without `rvalid_o[3]`.
- R9: During and after reset, `rvalid_o` and `err_o` are low. `ready_o` is low for any requester not requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 4 | Request per requester |
| we_i | input | 4 | Write enable per requester |
| addr_i | input | 4 x AW | Byte address per requester |
| wdata_i | input | 4 x 64 | Write data per requester |
| be_i | input | 4 x 8 | Byte strobes per requester |
| ready_o | output | 4 | Request accepted this cycle |
| rvalid_o | output | 4 | Read data valid, one cycle after grant |
| rdata_o | output | 4 x 64 | Read data per requester |
| err_o | output | 4 | Rejected write, one cycle after acceptance |

## Verification
A vector table drives request patterns that separate the cases the arbiter must tell apart:
- all four requesters on the instruction port, where only the top priority may win;
- same-bank and opposite-bank data pairs, which separate a true conflict from parallel service;
- mixed targets, where each port should have its own winner;
- a prefetch write alongside a normal request, which shows that the rejected write takes no port.

Directed sequences then cover the remaining behaviour:
- readback after concurrent writes, which shows the bank split;
- partial strobes on both memory widths;
- a prefetch write followed by a readback that proves the memory is unchanged;
- a held requester that is granted once the winner withdraws;
- a one-cycle `rvalid_o` that falls when no further request arrives.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int NREQ = 4;
  localparam int NRES = 3;
  localparam int IW   = 64;
  localparam int DW   = 32;

  localparam int REQ_DBG = 0;
  localparam int REQ_LSU = 1;
  localparam int REQ_SBU = 2;
  localparam int REQ_PFU = 3;

  typedef enum logic [1:0] {
    TGT_I  = 2'd0,
    TGT_D0 = 2'd1,
    TGT_D1 = 2'd2
  } tgt_e;
endpackage

// File: rtl/tcm_sram.sv
module tcm_sram #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int NB   = W / 8
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [NB-1:0] be_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) begin
        for (int b = 0; b < NB; b++) begin
          if (be_i[b]) mem[addr_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
        end
      end else begin
        rdata_o <= mem[addr_i];
      end
    end
  end
endmodule

// File: rtl/tcm_arb.sv
module tcm_arb
  import tcm_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [NREQ-1:0]          req_i,
  input  logic [NREQ-1:0]          we_i,
  input  logic [NREQ-1:0][AW-1:0]  addr_i,
  output logic [NREQ-1:0]          ready_o,
  output logic [NREQ-1:0]          gnt_o,
  output logic [NREQ-1:0]          perr_o,
  output tgt_e [NREQ-1:0]          tgt_o,
  output logic [NRES-1:0]          own_vld_o,
  output logic [NRES-1:0][1:0]     own_idx_o
);
  logic [NRES-1:0] busy;

  always_comb begin
    busy      = '0;
    ready_o   = '0;
    gnt_o     = '0;
    perr_o    = '0;
    own_vld_o = '0;
    own_idx_o = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (!addr_i[i][AW-1])  tgt_o[i] = TGT_I;
      else if (addr_i[i][2]) tgt_o[i] = TGT_D1;
      else                   tgt_o[i] = TGT_D0;
      // index order is priority order
      if (req_i[i]) begin
        if (i == REQ_PFU && we_i[i]) begin
          perr_o[i]  = 1'b1;
          ready_o[i] = 1'b1;
        end else if (!busy[int'(tgt_o[i])]) begin
          busy[int'(tgt_o[i])]      = 1'b1;
          gnt_o[i]                  = 1'b1;
          ready_o[i]                = 1'b1;
          own_vld_o[int'(tgt_o[i])] = 1'b1;
          own_idx_o[int'(tgt_o[i])] = 2'(i);
        end
      end
    end
  end
endmodule

// File: rtl/tcm_resp.sv
module tcm_resp
  import tcm_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NREQ-1:0]          gnt_i,
  input  logic [NREQ-1:0]          we_i,
  input  logic [NREQ-1:0]          perr_i,
  input  tgt_e [NREQ-1:0]          tgt_i,
  input  logic [IW-1:0]            i_rdata_i,
  input  logic [1:0][DW-1:0]       d_rdata_i,
  output logic [NREQ-1:0]          rvalid_o,
  output logic [NREQ-1:0]          err_o,
  output logic [NREQ-1:0][IW-1:0]  rdata_o
);
  tgt_e [NREQ-1:0] tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= '0;
      err_o    <= '0;
      tgt_q    <= {NREQ{TGT_I}};
    end else begin
      rvalid_o <= gnt_i & ~we_i;
      err_o    <= perr_i;
      tgt_q    <= tgt_i;
    end
  end

  for (genvar i = 0; i < NREQ; i++) begin : g_mux
    always_comb begin
      unique case (tgt_q[i])
        TGT_D0:  rdata_o[i] = {{(IW-DW){1'b0}}, d_rdata_i[0]};
        TGT_D1:  rdata_o[i] = {{(IW-DW){1'b0}}, d_rdata_i[1]};
        default: rdata_o[i] = i_rdata_i;
      endcase
    end
  end
endmodule

// File: rtl/tcm_arbiter.sv
module tcm_arbiter
  import tcm_pkg::*;
#(
  parameter int AW     = 12,
  parameter int IDEPTH = 64,
  parameter int DDEPTH = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [3:0]              req_i,
  input  logic [3:0]              we_i,
  input  logic [3:0][AW-1:0]      addr_i,
  input  logic [3:0][63:0]        wdata_i,
  input  logic [3:0][7:0]         be_i,
  output logic [3:0]              ready_o,
  output logic [3:0]              rvalid_o,
  output logic [3:0][63:0]        rdata_o,
  output logic [3:0]              err_o
);
  localparam int IAW = $clog2(IDEPTH);
  localparam int DAW = $clog2(DDEPTH);

  logic [NREQ-1:0]      gnt, perr;
  tgt_e [NREQ-1:0]      tgt;
  logic [NRES-1:0]      own_vld;
  logic [NRES-1:0][1:0] own_idx;
  logic [IW-1:0]        i_rdata;
  logic [1:0][DW-1:0]   d_rdata;
  logic                 unused_addr;

  assign unused_addr = ^addr_i;

  tcm_arb #(.AW(AW)) u_arb (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .ready_o   (ready_o),
    .gnt_o     (gnt),
    .perr_o    (perr),
    .tgt_o     (tgt),
    .own_vld_o (own_vld),
    .own_idx_o (own_idx)
  );

  logic [1:0] i_own;
  assign i_own = own_idx[int'(TGT_I)];

  tcm_sram #(.W(IW), .DEPTH(IDEPTH)) u_imem (
    .clk_i   (clk_i),
    .en_i    (own_vld[int'(TGT_I)]),
    .we_i    (we_i[i_own]),
    .be_i    (be_i[i_own]),
    .addr_i  (addr_i[i_own][3 +: IAW]),
    .wdata_i (wdata_i[i_own]),
    .rdata_o (i_rdata)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam int R = b + 1;
    logic [1:0] own;
    assign own = own_idx[R];

    tcm_sram #(.W(DW), .DEPTH(DDEPTH)) u_dmem (
      .clk_i   (clk_i),
      .en_i    (own_vld[R]),
      .we_i    (we_i[own]),
      .be_i    (be_i[own][DW/8-1:0]),
      .addr_i  (addr_i[own][3 +: DAW]),
      .wdata_i (wdata_i[own][DW-1:0]),
      .rdata_o (d_rdata[b])
    );
  end

  tcm_resp u_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gnt_i     (gnt),
    .we_i      (we_i),
    .perr_i    (perr),
    .tgt_i     (tgt),
    .i_rdata_i (i_rdata),
    .d_rdata_i (d_rdata),
    .rvalid_o  (rvalid_o),
    .err_o     (err_o),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/tcm_arbiter_chk.sv
module tcm_arbiter_chk #(
  parameter int AW = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [3:0]         req_i,
  input logic [3:0]         we_i,
  input logic [3:0][AW-1:0] addr_i,
  input logic [3:0]         ready_o,
  input logic [3:0]         rvalid_o,
  input logic [3:0]         err_o
);
  logic [3:0] use_d0, use_d1, use_i;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      use_i[i]  = req_i[i] && ready_o[i] && !(i == 3 && we_i[i]) && !addr_i[i][AW-1];
      use_d0[i] = req_i[i] && ready_o[i] && !(i == 3 && we_i[i]) && addr_i[i][AW-1] && !addr_i[i][2];
      use_d1[i] = req_i[i] && ready_o[i] && !(i == 3 && we_i[i]) && addr_i[i][AW-1] && addr_i[i][2];
    end
  end

  // R1
  dbg_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |-> ready_o[0]);

  // R2
  loser_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i[0] && req_i[1] && addr_i[0] == addr_i[1]) |-> !ready_o[1]);

  // R4
  one_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(use_i) <= 1 && $countones(use_d0) <= 1 && $countones(use_d1) <= 1);

  // R8
  pfu_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i[3] && we_i[3]) |=> (err_o[3] && !rvalid_o[3]));

  // R8
  err_only_pfu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o[2:0] == 3'b000);

  // R9
  ready_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o & ~req_i) == 4'b0000);

  for (genvar i = 0; i < 4; i++) begin : g_lat
    // R6
    rvalid_after_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[i] && ready_o[i] && !we_i[i]) |=> rvalid_o[i]);
    // R6
    rvalid_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rvalid_o[i] |-> $past(req_i[i] && ready_o[i] && !we_i[i]));
  end
endmodule

bind tcm_arbiter tcm_arbiter_chk #(.AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .ready_o  (ready_o),
  .rvalid_o (rvalid_o),
  .err_o    (err_o)
);

// File: tb/tcm_arbiter_bench.sv
module tcm_arbiter_bench;
  localparam int AW = 12;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [3:0]         req_i = '0;
  logic [3:0]         we_i = '0;
  logic [3:0][AW-1:0] addr_i = '0;
  logic [3:0][63:0]   wdata_i = '0;
  logic [3:0][7:0]    be_i = '0;
  logic [3:0]         ready_o, rvalid_o, err_o;
  logic [3:0][63:0]   rdata_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  tcm_arbiter #(.AW(AW)) u_tcm_arbiter (.*);

  typedef struct packed {
    logic [3:0]         req;
    logic [3:0]         we;
    logic [3:0][AW-1:0] addr;
    logic [3:0]         rdy;
  } vec_t;

  // addr packed as {pfu, sbus, lsu, dbg}; 0x0xx instr, 0x800 bank0, 0x804 bank1
  localparam vec_t VECS [8] = '{
    '{4'b1111, 4'b0000, {12'h000, 12'h008, 12'h010, 12'h018}, 4'b0001},
    '{4'b0110, 4'b0000, {12'h000, 12'h804, 12'h800, 12'h000}, 4'b0110},
    '{4'b0110, 4'b0000, {12'h000, 12'h808, 12'h800, 12'h000}, 4'b0010},
    '{4'b1111, 4'b0000, {12'h010, 12'h804, 12'h800, 12'h000}, 4'b0111},
    '{4'b1000, 4'b1000, {12'h010, 12'h000, 12'h000, 12'h000}, 4'b1000},
    '{4'b1001, 4'b1000, {12'h010, 12'h000, 12'h000, 12'h000}, 4'b1001},
    '{4'b1100, 4'b0000, {12'h010, 12'h018, 12'h000, 12'h000}, 4'b0100},
    '{4'b1110, 4'b0000, {12'h008, 12'h804, 12'h80c, 12'h000}, 4'b1010}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    req_i = '0; we_i = '0; addr_i = '0; wdata_i = '0; be_i = '0;
  endtask

  task automatic put(input int i, input logic we, input logic [AW-1:0] a,
                     input logic [63:0] d, input logic [7:0] be);
    req_i[i] = 1'b1; we_i[i] = we; addr_i[i] = a; wdata_i[i] = d; be_i[i] = be;
  endtask

  // called at negedge with inputs set: checks ready, advances one edge
  task automatic step(input string tag, input logic [3:0] exp_rdy);
    #1 chk(tag, 64'(ready_o), 64'(exp_rdy));
    @(negedge clk_i);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R9 reset rvalid", 64'(rvalid_o), 64'h0);
    chk("R9 reset err", 64'(err_o), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 idle ready", 64'(ready_o), 64'h0);
    chk("R9 idle rvalid", 64'(rvalid_o), 64'h0);

    // table: R1 R2 R4 R8 arbitration patterns, R6 rvalid follows grant
    for (int v = 0; v < 8; v++) begin
      req_i = VECS[v].req; we_i = VECS[v].we; addr_i = VECS[v].addr; be_i = '0;
      step($sformatf("R1 R4 vec%0d ready", v), VECS[v].rdy);
      chk($sformatf("R6 vec%0d rvalid", v), 64'(rvalid_o), 64'(VECS[v].rdy & ~VECS[v].we));
      chk($sformatf("R8 vec%0d err", v), 64'(err_o), 64'({VECS[v].req[3] & VECS[v].we[3], 3'b000}));
      clr();
    end

    // R4 concurrent writes to opposite banks
    put(1, 1'b1, 12'h800, 64'h11223344, 8'h0f);
    put(2, 1'b1, 12'h804, 64'h55667788, 8'h0f);
    step("R4 dual write ready", 4'b0110);
    chk("R6 write no rvalid", 64'(rvalid_o), 64'h0);
    clr();
    put(1, 1'b0, 12'h800, 64'h0, 8'h0);
    put(2, 1'b0, 12'h804, 64'h0, 8'h0);
    step("R4 dual read ready", 4'b0110);
    chk("R4 dual read rvalid", 64'(rvalid_o), 64'h6);
    chk("R3 R5 bank0 data", rdata_o[1], 64'h11223344);
    chk("R3 R5 bank1 data", rdata_o[2], 64'h55667788);
    clr();
    @(negedge clk_i);
    chk("R6 rvalid one cycle", 64'(rvalid_o), 64'h0);

    // R7 data byte strobe
    put(0, 1'b1, 12'h800, 64'hAABBCCDD, 8'h02);
    step("R7 dbg write ready", 4'b0001);
    clr();
    put(0, 1'b0, 12'h800, 64'h0, 8'h0);
    step("R7 dbg read ready", 4'b0001);
    chk("R7 data strobe", rdata_o[0], 64'h1122CC44);
    clr();

    // R5 R7 instruction side
    put(2, 1'b1, 12'h008, 64'hDEADBEEF_01234567, 8'hff);
    step("R5 sbus instr write", 4'b0100);
    clr();
    put(1, 1'b1, 12'h008, 64'hFF00_0000_0000_0000, 8'h80);
    step("R7 lsu instr write", 4'b0010);
    clr();
    put(3, 1'b0, 12'h008, 64'h0, 8'h0);
    step("R5 pfu read ready", 4'b1000);
    chk("R5 R7 instr 64b", rdata_o[3], 64'hFFADBEEF_01234567);
    clr();

    // R8 prefetch write rejected, memory intact
    put(3, 1'b1, 12'h008, 64'h0, 8'hff);
    step("R8 pfu write accepted", 4'b1000);
    chk("R8 err pulse", 64'(err_o), 64'h8);
    chk("R8 no rvalid", 64'(rvalid_o), 64'h0);
    clr();
    put(3, 1'b1, 12'h800, 64'h0, 8'hff);
    step("R8 pfu data write accepted", 4'b1000);
    clr();
    put(3, 1'b0, 12'h008, 64'h0, 8'h0);
    put(1, 1'b0, 12'h800, 64'h0, 8'h0);
    step("R8 readback ready", 4'b1010);
    chk("R8 err cleared", 64'(err_o), 64'h0);
    chk("R8 instr unchanged", rdata_o[3], 64'hFFADBEEF_01234567);
    chk("R8 data unchanged", rdata_o[1], 64'h1122CC44);
    clr();

    // R2 held requester granted once winner leaves
    put(0, 1'b0, 12'h008, 64'h0, 8'h0);
    put(1, 1'b0, 12'h008, 64'h0, 8'h0);
    step("R2 lsu held", 4'b0001);
    req_i[0] = 1'b0;
    step("R2 lsu granted", 4'b0010);
    chk("R2 lsu rvalid", 64'(rvalid_o), 64'h2);
    chk("R2 lsu data", rdata_o[1], 64'hFFADBEEF_01234567);
    clr();

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule